// File: doc/BRIEF.md
# Asymmetric I2C Serial Clock Generator

This block produces the serial clock for an I2C bus master. The low time and the high time of each clock period come from two independent 8-bit count fields. A 3-bit exponent field multiplies both counts by a power of two. A phase therefore lasts `count * 2^exponent + 3` system clock cycles. With a 30 MHz system clock, a configuration word of 0x047575 gives a 3750-cycle period, which is 8 kHz.

Next to the clock level, the block emits one-cycle strobes. One marks the first cycle of each low phase and one marks the first cycle of each high phase. A third marks the middle of the high phase, where the byte engine samples the data line. The byte engine drives the data line right after the low-phase strobe. The configuration word is read only when a phase begins, so software may rewrite it at any time without shortening or stretching the phase in progress. While the enable is low, the clock is parked high and the block is silent.

Top module: `i2c_clk_wavegen`

## Requirements
- R1: The configuration word packs the low count in bits 7:0, the high count in bits 15:8 and the exponent in bits 18:16. The word 0x047575 gives a low phase of 1875 cycles and a high phase of 1875 cycles, so the period is 3750 cycles.
- R2: Each low phase lasts `low_count * 2^exponent + 3` cycles of `clk`.
- R3: Each high phase lasts `high_count * 2^exponent + 3` cycles of `clk`.
- R4: A phase length that would exceed `2^CNT_W - 1` is clamped to `2^CNT_W - 1` cycles.
- R5: While `en` is low, `scl` is 1 and all three strobes are 0. Dropping `en` in the middle of a phase returns `scl` to 1 on the next cycle.
- R6: After `en` is sampled high from idle, `scl` goes to 0 on the next cycle, and `phase_low_stb` is 1 in that same cycle.
- R7: `phase_low_stb` is a one-cycle pulse in the first cycle of every low phase. `phase_high_stb` is a one-cycle pulse in the first cycle of every high phase. At most one strobe is active in any cycle.
- R8: `mid_high_stb` pulses exactly once per high phase, in cycle `floor(N/2)`, where N is the length of that high phase and the cycle of `phase_high_stb` counts as cycle 0.
- R9: A configuration change during a phase does not affect that phase. It applies from the next phase start.
- R10: During reset (`rst` = 1), `scl` is 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the generator; low parks the clock high |
| cfg | input | 19 | {exponent[2:0], high_count[7:0], low_count[7:0]} |
| scl | output | 1 | Serial clock level |
| phase_low_stb | output | 1 | First cycle of a low phase |
| phase_high_stb | output | 1 | First cycle of a high phase |
| mid_high_stb | output | 1 | Middle cycle of a high phase |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Off-by-one phase lengths.** A design that counted one cycle too many or too few would put every edge a cycle late or early. The cycle-by-cycle comparison catches this on the first edge.
- **Configuration rewritten mid-phase.** A generator that sampled the word continuously would cut the running low phase short. The bench checks that the running phase keeps its old length.
- **Clamping.** A second instance with a narrow counter is driven with the largest exponent. A counter that wrapped instead of clamping would give a short phase instead of 1023 cycles.
- **Disable in mid-high.** The bench drops `en` during a high phase. A design that finished the period first would keep strobing.
- **Mid-high position.** The bench checks the strobe position for odd high-phase lengths, where halving the length could be rounded the wrong way.

// File: rtl/i2c_cwg_pkg.sv
package i2c_cwg_pkg;
  localparam int DIV_W_DEF = 8;
  localparam int PRE_W_DEF = 3;
  localparam int CNT_W_DEF = 15;
  localparam int PHASE_OVERHEAD = 3;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/cwg_phase_len.sv
module cwg_phase_len #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 3,
  parameter int CNT_W = 15
) (
  input  logic [DIV_W-1:0] div,
  input  logic [PRE_W-1:0] pre,
  output logic [CNT_W-1:0] len
);
  import i2c_cwg_pkg::*;

  localparam int SHIFT_MAX = (1 << PRE_W) - 1;
  localparam int FULL_W    = DIV_W + SHIFT_MAX + 1;

  logic [FULL_W-1:0] full;

  always_comb begin
    full = (FULL_W'(div) << pre) + FULL_W'(PHASE_OVERHEAD);
  end

  generate
    if (CNT_W >= FULL_W) begin : g_wide
      assign len = CNT_W'(full);
    end else begin : g_clamp
      localparam logic [FULL_W-1:0] MAXC = FULL_W'((1 << CNT_W) - 1);
      assign len = (full > MAXC) ? CNT_W'(MAXC) : CNT_W'(full);
    end
  endgenerate
endmodule

// File: rtl/cwg_phase_seq.sv
module cwg_phase_seq #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] len_low,
  input  logic [CNT_W-1:0] len_high,
  output logic             scl_o,
  output logic             low_stb_o,
  output logic             high_stb_o,
  output logic             mid_stb_o
);
  import i2c_cwg_pkg::*;

  logic             active_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             last;
  logic [CNT_W-1:0] cnt_nx;

  assign last   = (cnt_q == len_q - CNT_W'(1));
  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active_q   <= 1'b0;
      phase_q    <= PH_HIGH;
      cnt_q      <= '0;
      len_q      <= '0;
      low_stb_o  <= 1'b0;
      high_stb_o <= 1'b0;
      mid_stb_o  <= 1'b0;
    end else if (!active_q) begin
      active_q   <= 1'b1;
      phase_q    <= PH_LOW;
      cnt_q      <= '0;
      len_q      <= len_low;
      low_stb_o  <= 1'b1;
      high_stb_o <= 1'b0;
      mid_stb_o  <= 1'b0;
    end else if (last) begin
      cnt_q      <= '0;
      mid_stb_o  <= 1'b0;
      if (phase_q == PH_HIGH) begin
        phase_q    <= PH_LOW;
        len_q      <= len_low;
        low_stb_o  <= 1'b1;
        high_stb_o <= 1'b0;
      end else begin
        phase_q    <= PH_HIGH;
        len_q      <= len_high;
        low_stb_o  <= 1'b0;
        high_stb_o <= 1'b1;
      end
    end else begin
      cnt_q      <= cnt_nx;
      low_stb_o  <= 1'b0;
      high_stb_o <= 1'b0;
      mid_stb_o  <= (phase_q == PH_HIGH) && (cnt_nx == (len_q >> 1));
    end
  end

  assign scl_o = (phase_q == PH_HIGH);

  assert_idle_parked_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !low_stb_o && !high_stb_o && !mid_stb_o));

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_stb_o, high_stb_o, mid_stb_o}));

  assert_edge_has_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(scl_o)) |-> (low_stb_o || high_stb_o));

  assert_low_stb_level_R7: assert property (@(posedge clk) disable iff (rst)
    low_stb_o |-> !scl_o);

  assert_mid_in_high_R8: assert property (@(posedge clk) disable iff (rst)
    (mid_stb_o || high_stb_o) |-> scl_o);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < len_q));
endmodule

// File: rtl/i2c_clk_wavegen.sv
module i2c_clk_wavegen #(
  parameter int DIV_W = i2c_cwg_pkg::DIV_W_DEF,
  parameter int PRE_W = i2c_cwg_pkg::PRE_W_DEF,
  parameter int CNT_W = i2c_cwg_pkg::CNT_W_DEF,
  localparam int CFG_W = 2 * DIV_W + PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg,
  output logic             scl,
  output logic             phase_low_stb,
  output logic             phase_high_stb,
  output logic             mid_high_stb
);
  localparam int NPH   = 2;
  localparam int PRE_LO = 2 * DIV_W;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] len [NPH];

  assign pre = cfg[PRE_LO +: PRE_W];

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_len
      cwg_phase_len #(
        .DIV_W(DIV_W),
        .PRE_W(PRE_W),
        .CNT_W(CNT_W)
      ) u_len (
        .div(cfg[g*DIV_W +: DIV_W]),
        .pre(pre),
        .len(len[g])
      );
    end
  endgenerate

  cwg_phase_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .len_low   (len[0]),
    .len_high  (len[1]),
    .scl_o     (scl),
    .low_stb_o (phase_low_stb),
    .high_stb_o(phase_high_stb),
    .mid_stb_o (mid_high_stb)
  );
endmodule

// File: tb/tb_i2c_clk_wavegen.sv
module tb_i2c_clk_wavegen;
  localparam int CNT_MAIN = 15;
  localparam int CNT_SAT  = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [18:0] cfg = '0;

  logic scl_a, ls_a, hs_a, mh_a;
  logic scl_b, ls_b, hs_b, mh_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit sel_sat = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_clk_wavegen #(.CNT_W(CNT_MAIN)) dut (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg),
    .scl(scl_a), .phase_low_stb(ls_a), .phase_high_stb(hs_a), .mid_high_stb(mh_a));

  i2c_clk_wavegen #(.CNT_W(CNT_SAT)) dut_sat (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg),
    .scl(scl_b), .phase_low_stb(ls_b), .phase_high_stb(hs_b), .mid_high_stb(mh_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int plen(input int d, input int p, input int w);
    int v;
    v = d * (1 << p) + 3;
    if (v > (1 << w) - 1) v = (1 << w) - 1;
    return v;
  endfunction

  // Behavioural reference for the main instance
  bit m_act = 0, m_scl = 1, m_ls = 0, m_hs = 0, m_mh = 0;
  int m_el = 0, m_len = 0;

  always @(posedge clk) begin
    if (rst || !en) begin
      m_act = 0; m_scl = 1; m_el = 0; m_ls = 0; m_hs = 0; m_mh = 0;
    end else if (!m_act) begin
      m_act = 1; m_scl = 0; m_el = 0; m_ls = 1; m_hs = 0; m_mh = 0;
      m_len = plen(cfg[7:0], cfg[18:16], CNT_MAIN);
    end else if (m_el == m_len - 1) begin
      m_scl = !m_scl; m_el = 0; m_mh = 0;
      m_ls = !m_scl; m_hs = m_scl;
      m_len = m_scl ? plen(cfg[15:8], cfg[18:16], CNT_MAIN)
                    : plen(cfg[7:0], cfg[18:16], CNT_MAIN);
    end else begin
      m_el++; m_ls = 0; m_hs = 0;
      m_mh = m_scl && (m_el == m_len / 2);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(scl_a == m_scl, "R2/R3 scl level", scl_a, m_scl);
      chk({ls_a, hs_a} == {m_ls, m_hs}, "R7 phase strobes", {ls_a, hs_a}, {m_ls, m_hs});
      chk(mh_a == m_mh, "R8 mid-high strobe", mh_a, m_mh);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // 0: low strobe, 1: high strobe, 2: mid strobe
  function automatic logic get(input int k);
    logic [2:0] v;
    v = sel_sat ? {mh_b, hs_b, ls_b} : {mh_a, hs_a, ls_a};
    return v[k];
  endfunction

  task automatic wait_for(input int k);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!get(k) && t < 40000);
  endtask

  task automatic gap(input int k, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!get(k) && n < 40000);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(scl_a == 1 && {ls_a, hs_a, mh_a} == 0, "R10 reset state", scl_a, 1);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(scl_a == 1 && {ls_a, hs_a, mh_a} == 0, "R5 idle parked", scl_a, 1);
    end

    // exponent 1, high 3, low 2: low 7, high 9
    cfg = {3'd1, 8'd3, 8'd2};
    en = 1'b1;
    @(negedge clk);
    chk(scl_a == 0 && ls_a == 1, "R6 start low", {scl_a, ls_a}, 1);
    gap(1, n); chk(n == 7, "R2 low length", n, 7);
    gap(2, n); chk(n == 4, "R8 mid position", n, 4);
    gap(0, n); chk(n == 5, "R3 high length remainder", n, 5);
    gap(1, n); chk(n == 7, "R2 low length again", n, 7);
    gap(0, n); chk(n == 9, "R3 high length", n, 9);

    // R9: rewrite during a low phase
    repeat (2) @(negedge clk);
    cfg = {3'd0, 8'd2, 8'd1};
    gap(1, n); chk(n + 2 == 7, "R9 running low kept", n + 2, 7);
    gap(0, n); chk(n == 5, "R9 new high applied", n, 5);
    gap(1, n); chk(n == 4, "R9 new low applied", n, 4);
    gap(2, n); chk(n == 2, "R8 mid position odd", n, 2);

    // R5: drop enable in mid-high
    wait_for(1);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_a == 1, "R5 disable returns high", scl_a, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk({ls_a, hs_a, mh_a} == 0 && scl_a, "R5 silent when disabled", {ls_a, hs_a, mh_a}, 0);
    end

    // R1: packed example word
    cfg = 19'h047575;
    en = 1'b1;
    @(negedge clk);
    gap(1, n); chk(n == 1875, "R1 low from packed word", n, 1875);
    gap(0, n); chk(n == 1875, "R1 high from packed word", n, 1875);
    en = 1'b0;
    @(negedge clk);
    cfg = 19'h040575;
    en = 1'b1;
    @(negedge clk);
    gap(1, n); chk(n == 1875, "R1 low field bits 7:0", n, 1875);
    gap(0, n); chk(n == 83, "R1 high field bits 15:8", n, 83);

    // R4: clamping on the narrow instance
    en = 1'b0;
    @(negedge clk);
    cfg = {3'd7, 8'd1, 8'd255};
    sel_sat = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk(ls_b == 1, "R6 narrow start", ls_b, 1);
    gap(1, n); chk(n == 1023, "R4 clamped low", n, 1023);
    gap(0, n); chk(n == 131, "R4 unclamped high", n, 131);
    en = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule